// File: doc/BRIEF.md
# Synchronous Sync-Hunt Character Receiver

This block is the receive-side deserialiser of a character-oriented synchronous serial link. Serial data is sampled on every rising edge of a receive clock supplied from outside, least significant bit first. After reset the block is in hunt mode. It slides an eight-bit window over the bit stream one bit at a time, looking for a programmable sync character. Because the match is tried on every bit, the character boundary can fall at any bit offset in the stream.

When the sync character is found, the block enters framing mode. From then on every eight bits form one character, and characters follow one another with no gap. Each data character appears on the byte output together with a strobe one clock long. The byte then stays unchanged until the next data character. Sync characters that arrive on a character boundary, whether as idle fill or just before a block, are flagged on a pulse output and are never delivered as data. When the programmable end code arrives on a boundary, the block pulses an end flag and returns to hunting.

Top module: `sync_char_rx`

## Requirements
- R1: While reset is active and on the first edge after it, `char_valid`, `end_seen`, `sync_hit` and `in_sync` are 0 and `char_out` is 0x00.
- R2: `rx_data` is sampled on each rising edge of `rx_clk`. The first bit of a character is its bit 0 (least significant bit first).
- R3: In hunt mode the last eight sampled bits are compared with `sync_pat` on every edge. On a match, `in_sync` and a one-edge `sync_hit` pulse rise right after the edge that sampled the eighth bit, whatever the bit offset of the match.
- R4: In framing mode every eight bits form one character. A data character is placed on `char_out`, and `char_valid` is 1 for exactly one edge, right after the edge that sampled its eighth bit. Characters follow back to back.
- R5: `char_out` changes only together with a `char_valid` pulse.
- R6: A character equal to `sync_pat` received on a boundary in framing mode pulses `sync_hit`, gives no strobe and keeps `in_sync` at 1. The following eight bits form the next character.
- R7: A character equal to `end_code` (and not equal to `sync_pat`) received on a boundary in framing mode pulses `end_seen` for one edge, clears `in_sync` and gives no strobe. `char_out` is left unchanged.
- R8: In hunt mode no `char_valid` pulse is produced, whatever data arrives, until a sync match occurs.
- R9: A sync match needs eight bits sampled since reset. The window bits not yet sampled never count toward a match, even when `sync_pat` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive clock; data is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_data | input | 1 | Serial receive data |
| sync_pat | input | 8 | Sync character to hunt for |
| end_code | input | 8 | End-of-text character that ends framing |
| char_out | output | 8 | Last received data character |
| char_valid | output | 1 | One-cycle strobe for a new character on `char_out` |
| in_sync | output | 1 | 1 while in framing mode |
| end_seen | output | 1 | One-cycle pulse when the end code is received |
| sync_hit | output | 1 | One-cycle pulse when a sync character is recognised |

## Verification
Every result is registered, so it appears right after the rising edge that samples the last bit of the character concerned. There is no further latency. The bench changes `rx_data` one nanosecond after an edge and reads the outputs one nanosecond after the following edge. It therefore sees each bit's effect before the next bit is driven. For every character it sends, the bench records which of the eight bit positions raised a strobe or a pulse. It expects a pulse only at position seven and exactly once, and it checks the hold and mode flags after the eighth bit.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
    localparam int unsigned CHAR_W = 8;

    typedef enum logic {
        ST_HUNT  = 1'b0,
        ST_FRAME = 1'b1
    } rx_state_e;
endpackage

// File: rtl/sync_rx_window.sv
module sync_rx_window #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_in,
    output logic [W-1:0] win_next,
    output logic         win_full
);
    localparam int unsigned FW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  win;
        logic [FW-1:0] fill;
    } win_regs_t;

    win_regs_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        // newest bit enters at the top, so the first bit ends in bit 0
        r_d.win = {bit_in, r_q.win[W-1:1]};
        if (r_q.fill != FW'(W)) begin
            r_d.fill = r_q.fill + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign win_next = r_d.win;
    assign win_full = (r_q.fill >= FW'(W - 1));

    assert_fill_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.fill <= FW'(W));
    assert_fill_steps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.fill != FW'(W)) |=> (r_q.fill == $past(r_q.fill) + 1'b1));
endmodule

// File: rtl/sync_rx_bitcnt.sv
module sync_rx_bitcnt #(
    parameter int unsigned W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_regs_t;

    cnt_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (!run) begin
            r_d.cnt = '0;
        end else if (r_q.cnt == CW'(W - 1)) begin
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign last = run && (r_q.cnt == CW'(W - 1));

    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= CW'(W - 1));
    assert_cnt_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (r_q.cnt == '0));
endmodule

// File: rtl/sync_char_rx.sv
module sync_char_rx
    import sync_rx_pkg::*;
#(
    parameter int unsigned CHAR_BITS = CHAR_W
) (
    input  logic                 rx_clk,
    input  logic                 rst_n,
    input  logic                 rx_data,
    input  logic [CHAR_BITS-1:0] sync_pat,
    input  logic [CHAR_BITS-1:0] end_code,
    output logic [CHAR_BITS-1:0] char_out,
    output logic                 char_valid,
    output logic                 in_sync,
    output logic                 end_seen,
    output logic                 sync_hit
);
    typedef struct packed {
        rx_state_e            st;
        logic [CHAR_BITS-1:0] chr;
        logic                 vld;
        logic                 endp;
        logic                 synp;
    } ctl_regs_t;

    ctl_regs_t r_q, r_d;

    logic [CHAR_BITS-1:0] win_next;
    logic                 win_full;
    logic                 char_last;
    logic                 framing;

    assign framing = (r_q.st == ST_FRAME);

    sync_rx_window #(.W(CHAR_BITS)) u_window (
        .clk      (rx_clk),
        .rst_n    (rst_n),
        .bit_in   (rx_data),
        .win_next (win_next),
        .win_full (win_full)
    );

    sync_rx_bitcnt #(.W(CHAR_BITS)) u_bitcnt (
        .clk   (rx_clk),
        .rst_n (rst_n),
        .run   (framing),
        .last  (char_last)
    );

    always_comb begin
        r_d      = r_q;
        r_d.vld  = 1'b0;
        r_d.endp = 1'b0;
        r_d.synp = 1'b0;
        unique case (r_q.st)
            ST_HUNT: begin
                if (win_full && (win_next == sync_pat)) begin
                    r_d.st   = ST_FRAME;
                    r_d.synp = 1'b1;
                end
            end
            ST_FRAME: begin
                if (char_last) begin
                    if (win_next == sync_pat) begin
                        r_d.synp = 1'b1;
                    end else if (win_next == end_code) begin
                        r_d.endp = 1'b1;
                        r_d.st   = ST_HUNT;
                    end else begin
                        r_d.chr = win_next;
                        r_d.vld = 1'b1;
                    end
                end
            end
            default: r_d.st = ST_HUNT;
        endcase
    end

    always_ff @(posedge rx_clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_HUNT, chr: '0, vld: 1'b0, endp: 1'b0, synp: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign char_out   = r_q.chr;
    assign char_valid = r_q.vld;
    assign in_sync    = framing;
    assign end_seen   = r_q.endp;
    assign sync_hit   = r_q.synp;

    assert_strobe_framed_R4: assert property (@(posedge rx_clk) disable iff (!rst_n)
        char_valid |-> in_sync);
    assert_strobe_single_R4: assert property (@(posedge rx_clk) disable iff (!rst_n)
        char_valid |=> !char_valid);
    assert_char_hold_R5: assert property (@(posedge rx_clk) disable iff (!rst_n)
        !char_valid |-> $stable(char_out));
    assert_sync_entry_R3: assert property (@(posedge rx_clk) disable iff (!rst_n)
        $rose(in_sync) |-> sync_hit);
    assert_end_exit_R7: assert property (@(posedge rx_clk) disable iff (!rst_n)
        end_seen |-> (!in_sync && !char_valid && !sync_hit));
    assert_end_single_R7: assert property (@(posedge rx_clk) disable iff (!rst_n)
        end_seen |=> !end_seen);
    assert_hunt_quiet_R8: assert property (@(posedge rx_clk) disable iff (!rst_n)
        !in_sync |=> !char_valid);
    assert_sync_no_data_R6: assert property (@(posedge rx_clk) disable iff (!rst_n)
        sync_hit |-> (!char_valid && in_sync));
endmodule

// File: tb/sync_char_rx_bench.sv
module sync_char_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_data = 1'b0;
    logic [7:0] sync_pat = 8'h16;
    logic [7:0] end_code = 8'h04;
    logic [7:0] char_out;
    logic       char_valid, in_sync, end_seen, sync_hit;

    int n_checks = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // per-byte observations
    int n_vld, n_end, n_syn, vld_pos;

    always #5 clk = ~clk;

    sync_char_rx u_sync_char_rx (
        .rx_clk     (clk),
        .rst_n      (rst_n),
        .rx_data    (rx_data),
        .sync_pat   (sync_pat),
        .end_code   (end_code),
        .char_out   (char_out),
        .char_valid (char_valid),
        .in_sync    (in_sync),
        .end_seen   (end_seen),
        .sync_hit   (sync_hit)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rx_data = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    // drive one bit after an edge, observe one ns after the sampling edge
    task automatic send_bit(input logic b);
        rx_data = b;
        @(posedge clk);
        #1;
    endtask

    task automatic send_byte(input logic [7:0] v);
        n_vld = 0; n_end = 0; n_syn = 0; vld_pos = -1;
        for (int i = 0; i < 8; i++) begin
            send_bit(v[i]);
            if (char_valid) begin n_vld++; vld_pos = i; end
            if (end_seen) n_end++;
            if (sync_hit) n_syn++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check(!char_valid && !end_seen && !sync_hit && !in_sync, "R1 flags in reset",
              {char_valid, end_seen, sync_hit, in_sync}, 0);
        check(char_out == 8'h00, "R1 char_out in reset", char_out, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(!char_valid && !in_sync && !sync_hit && !end_seen, "R1 first edge after reset",
              {char_valid, end_seen, sync_hit, in_sync}, 0);
    endtask

    task automatic t_fill();
        int early = 0;
        sync_pat = 8'h00;
        do_reset();
        for (int i = 0; i < 7; i++) begin
            send_bit(1'b0);
            if (in_sync || sync_hit) early++;
        end
        check(early == 0, "R9 no match before eight bits", early, 0);
        send_bit(1'b0);
        check(in_sync && sync_hit, "R9 match on eighth bit", {in_sync, sync_hit}, 3);
        sync_pat = 8'h16;
        do_reset();
    endtask

    task automatic t_hunt_noise();
        int v = 0;
        int s = 0;
        send_byte(8'hFF); v += n_vld; s += n_syn;
        send_byte(8'h00); v += n_vld; s += n_syn;
        send_byte(8'hAA); v += n_vld; s += n_syn;
        check(v == 0, "R8 no strobe while hunting", v, 0);
        check(s == 0 && !in_sync, "R3 no false sync", s, 0);
    endtask

    task automatic t_lock_offset();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        send_byte(8'h16);
        check(n_syn == 1 && in_sync, "R3 sync found at odd offset", n_syn, 1);
        check(n_vld == 0, "R6 sync not delivered", n_vld, 0);
    endtask

    task automatic t_data();
        send_byte(8'h1E);
        check(n_vld == 1 && vld_pos == 7, "R4 strobe on eighth bit", vld_pos, 7);
        check(char_out == 8'h1E, "R2 lsb-first assembly", char_out, 8'h1E);
        send_bit(1'b0);
        check(!char_valid && char_out == 8'h1E, "R5 held after strobe", char_out, 8'h1E);
        for (int i = 1; i < 8; i++) send_bit(1'b1);
        check(char_valid && char_out == 8'hFE, "R4 back-to-back character", char_out, 8'hFE);
        send_byte(8'h3C);
        check(n_vld == 1 && char_out == 8'h3C, "R4 third character", char_out, 8'h3C);
    endtask

    task automatic t_resync();
        send_byte(8'h16);
        check(n_syn == 1 && n_vld == 0, "R6 sync in frame flagged only", n_vld, 0);
        check(in_sync && char_out == 8'h3C, "R6 stays framed, byte held", char_out, 8'h3C);
        send_byte(8'h72);
        check(n_vld == 1 && vld_pos == 7 && char_out == 8'h72, "R6 alignment after sync",
              char_out, 8'h72);
    endtask

    task automatic t_end();
        send_byte(8'h04);
        check(n_end == 1 && n_vld == 0, "R7 end pulse without strobe", n_end, 1);
        check(!in_sync && char_out == 8'h72, "R7 back to hunt, byte held", char_out, 8'h72);
        send_byte(8'hC3);
        check(n_end == 0 && n_vld == 0, "R7 end pulse is single", n_end, 0);
        send_byte(8'h99);
        check(n_vld == 0 && !in_sync && char_out == 8'h72, "R8 data ignored after end",
              char_out, 8'h72);
    endtask

    initial begin
        t_reset();
        t_fill();
        t_hunt_noise();
        t_lock_offset();
        t_data();
        t_resync();
        t_end();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end
endmodule